// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block sits next to a small processor core and decides which of ten maskable interrupt sources is serviced next. Each source owns a pending flag, an individual enable and a one-bit level (high or low). Every clock the arbiter looks at all enabled pending flags. A high-level request always beats a low-level one. Among requests of equal level, the source with the lower index wins.

At an instruction boundary the block can raise a call request to the core, carrying the vector address of the winner. The request and its vector then stay frozen until the core acknowledges the call. On acknowledge, the block marks the winner's level as in service. For sources 0 to 3 it also clears the pending flag. The other sources keep their flags until software clears them.

A return strobe frees the most important level in service. The boundary that carries the return never starts a call, so at least one further instruction completes first. A stall from the core blocks any new call for as long as it lasts.

Top module: `irq_nest_ctl`

## Requirements
- R1: A one-cycle pulse on `src_raise[i]` makes `pend_flags[i]` read 1 after the next clock edge. When raise and software clear of the same source coincide, the flag ends up set.
- R2: `sw_clear[i]` without a raise clears `pend_flags[i]` at the next edge. Acknowledge of a call clears the winner's flag only for sources 0 to 3; sources 4 to 9 keep their flag set.
- R3: A source takes part in arbitration only when its `src_en` bit and `glb_en` are both 1.
- R4: Any eligible request with `src_hi` = 1 wins over every eligible request with `src_hi` = 0, whatever their indices.
- R5: Among eligible requests of the same level, the lowest index wins.
- R6: `call_vec` of a call for source i equals 0x0003 + 8*i (16 bits). `call_vec` reads 0x0000 after reset.
- R7: `call_req` rises only after a clock edge at which `insn_done` = 1 and `reti_done` = 0. Once raised, it and `call_vec` hold until the edge at which `call_ack` = 1, and `call_req` is 0 after that edge.
- R8: `in_service` bit 1 is the high level and bit 0 is the low level. Acknowledge sets the bit of the winner's level. `reti_done` clears bit 1 if it is set, otherwise bit 0.
- R9: A low-level winner is called only while `in_service` = 00. A high-level winner is called only while `in_service[1]` = 0, so it can preempt a low-level handler.
- R10: A boundary with `reti_done` = 1 never starts a call. A request that is pending at a return is called at the following boundary at the earliest.
- R11: While `stall` = 1, no call is started. The missed boundary is not remembered.
- R12: After reset, `call_req` = 0, `call_vec` = 0x0000, `pend_flags` = 0 and `in_service` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_raise | input | 10 | Per-source event pulse setting the pending flag |
| sw_clear | input | 10 | Per-source software clear of the pending flag |
| src_en | input | 10 | Per-source enable |
| src_hi | input | 10 | Per-source level, 1 = high |
| glb_en | input | 1 | Global enable for all maskable sources |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| reti_done | input | 1 | The instruction ending now is a return from interrupt |
| stall | input | 1 | Core stalled; no call may start |
| call_ack | input | 1 | Core takes the presented call |
| call_req | output | 1 | Call request to the core |
| call_vec | output | 16 | Vector address of the requested call |
| pend_flags | output | 10 | Current pending flags |
| in_service | output | 2 | Levels in service, bit 1 high, bit 0 low |

## Verification
A corrupted in-service register shows up as a missing or unexpected call at the next instruction boundary with something pending. A stuck low-level bit starves every low-level source. A lost high-level bit lets a second high-level call nest. A wrong winner or vector is visible on `call_vec` one clock after the boundary. A pending flag that is cleared or kept wrongly shows up on `pend_flags` one edge after the acknowledge or clear. Mistakes in the return gap or stall gating appear as a call request one boundary too early.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  function automatic int unsigned vec_addr(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned step);
    return base + idx * step;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N           = 10,
  parameter logic [N-1:0] HW_CLR_MSK = 10'b00_0000_1111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] sw_clear,
  input  logic [N-1:0] hw_take,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] drop;

  always_comb begin
    drop   = sw_clear | (hw_take & HW_CLR_MSK);
    pend_d = (pend_q & ~drop) | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R1: a raise is always visible one edge later
  assert_raise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    |raise |=> ((pend_q & $past(raise)) == $past(raise)));

  // R2: clears without a concurrent raise take effect one edge later
  assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |((sw_clear | (hw_take & HW_CLR_MSK)) & ~raise)
      |=> ((pend_q & $past((sw_clear | (hw_take & HW_CLR_MSK)) & ~raise)) == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = 10,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     en,
  input  logic [N-1:0]     hi,
  input  logic             glb_en,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_hi
);
  logic [N-1:0] elig, hi_req, lo_req, cand, below, grant;

  assign elig   = pend & en & {N{glb_en}};
  assign hi_req = elig & hi;
  assign lo_req = elig & ~hi;
  assign cand   = (|hi_req) ? hi_req : lo_req;

  // lowest-index-first one-hot grant through a prefix OR chain
  assign below[0] = 1'b0;
  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign below[i] = below[i-1] | cand[i-1];
    end
  endgenerate
  assign grant = cand & ~below;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) win_idx = win_idx | IDX_W'(i);
    end
  end

  assign win_vld = |grant;
  assign win_hi  = |hi_req;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_nest_pkg::*;
#(
  parameter int unsigned N        = 10,
  parameter int unsigned IDX_W    = $clog2(N),
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_hi,
  input  logic             insn_done,
  input  logic             reti_done,
  input  logic             stall,
  input  logic             call_ack,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic [N-1:0]     hw_take,
  output logic [1:0]       in_svc
);
  logic             req_q, req_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  lvl_e             lvl_q, lvl_d;
  logic [1:0]       isr_q, isr_d;
  logic             allowed, fire, take, upd;

  assign allowed = win_vld && (win_hi ? !isr_q[LVL_HI] : (isr_q == 2'b00));
  assign fire    = !req_q && insn_done && !reti_done && !stall && allowed;
  assign take    = req_q && call_ack;
  assign upd     = fire || take || reti_done;

  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    idx_d = idx_q;
    lvl_d = lvl_q;
    isr_d = isr_q;
    if (reti_done) begin
      if (isr_q[LVL_HI]) isr_d[LVL_HI] = 1'b0;
      else               isr_d[LVL_LO] = 1'b0;
    end
    if (fire) begin
      req_d = 1'b1;
      vec_d = VEC_W'(vec_addr(int'(win_idx), VEC_BASE, VEC_STEP));
      idx_d = win_idx;
      lvl_d = win_hi ? LVL_HI : LVL_LO;
    end else if (take) begin
      req_d        = 1'b0;
      isr_d[lvl_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      idx_q <= '0;
      lvl_q <= LVL_LO;
      isr_q <= 2'b00;
    end else if (upd) begin
      req_q <= req_d;
      vec_q <= vec_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
      isr_q <= isr_d;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_take
      assign hw_take[i] = take && (idx_q == IDX_W'(i));
    end
  endgenerate

  assign call_req = req_q;
  assign call_vec = vec_q;
  assign in_svc   = isr_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !call_ack) |=> (req_q && $stable(vec_q)));
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && call_ack) |=> !req_q);
  assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(insn_done && !reti_done)) |=> !req_q);
  assert_ret_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && reti_done) |=> !req_q);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && stall) |=> !req_q);
  assert_svc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && call_ack) |=> isr_q[$past(lvl_q)]);
  assert_lo_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && (isr_q != 2'b00)) |=> !(req_q && (lvl_q == LVL_LO)));
  assert_hi_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && isr_q[LVL_HI]) |=> !req_q);

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl #(
  parameter int unsigned N           = 10,
  parameter int unsigned VEC_W       = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STEP    = 8,
  parameter logic [N-1:0] HW_CLR_MSK = 10'b00_0000_1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_raise,
  input  logic [N-1:0]     sw_clear,
  input  logic [N-1:0]     src_en,
  input  logic [N-1:0]     src_hi,
  input  logic             glb_en,
  input  logic             insn_done,
  input  logic             reti_done,
  input  logic             stall,
  input  logic             call_ack,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic [N-1:0]     pend_flags,
  output logic [1:0]       in_service
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     pend, hw_take;
  logic             win_vld, win_hi;
  logic [IDX_W-1:0] win_idx;

  irq_pend_bank #(.N(N), .HW_CLR_MSK(HW_CLR_MSK)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise(src_raise), .sw_clear(sw_clear),
    .hw_take(hw_take), .pend(pend)
  );

  irq_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .en(src_en), .hi(src_hi), .glb_en(glb_en),
    .win_vld(win_vld), .win_idx(win_idx), .win_hi(win_hi)
  );

  irq_seq #(.N(N), .IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
            .VEC_STEP(VEC_STEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_idx(win_idx),
    .win_hi(win_hi), .insn_done(insn_done), .reti_done(reti_done),
    .stall(stall), .call_ack(call_ack), .call_req(call_req),
    .call_vec(call_vec), .hw_take(hw_take), .in_svc(in_service)
  );

  assign pend_flags = pend;

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !win_vld);
  assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !win_hi) |-> ((pend & src_en & src_hi) == '0));
  assert_low_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (pend[win_idx] && src_en[win_idx] && (src_hi[win_idx] == win_hi)));

endmodule

// File: tb/irq_nest_ctl_tb_top.sv
module irq_nest_ctl_tb_top;
  localparam int N = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_raise, sw_clear, src_en, src_hi;
  logic          glb_en, insn_done, reti_done, stall, call_ack;
  logic          call_req;
  logic [15:0]   call_vec;
  logic [N-1:0]  pend_flags;
  logic [1:0]    in_service;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  irq_nest_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .sw_clear(sw_clear),
    .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .insn_done(insn_done),
    .reti_done(reti_done), .stall(stall), .call_ack(call_ack),
    .call_req(call_req), .call_vec(call_vec), .pend_flags(pend_flags),
    .in_service(in_service)
  );

  // {raise, hi, expected index (15 = no call)}
  localparam logic [23:0] TBL [0:7] = '{
    {10'b00_0000_0001, 10'b00_0000_0000, 4'd0},
    {10'b10_0000_0000, 10'b00_0000_0000, 4'd9},
    {10'b11_1111_1110, 10'b00_0000_0000, 4'd1},
    {10'b00_0001_0100, 10'b00_0000_0000, 4'd2},
    {10'b10_0000_0001, 10'b10_0000_0000, 4'd9},
    {10'b00_0011_0000, 10'b00_0010_0000, 4'd5},
    {10'b00_0011_0000, 10'b00_0011_0000, 4'd4},
    {10'b00_0000_0000, 10'b00_0000_0000, 4'd15}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    src_raise = '0; sw_clear = '0; insn_done = 1'b0;
    reti_done = 1'b0; call_ack = 1'b0;
  endtask

  task automatic clear_all();
    sw_clear = '1; step();
    src_hi = '0;
  endtask

  task automatic ack_and_return(input int levels);
    call_ack = 1'b1; step();
    for (int k = 0; k < levels; k++) begin
      reti_done = 1'b1; insn_done = 1'b1; step();
    end
  endtask

  initial begin
    #(8 * 50000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_raise = '0; sw_clear = '0; src_en = '1; src_hi = '0;
    glb_en = 1'b1; insn_done = 1'b0; reti_done = 1'b0; stall = 1'b0;
    call_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 call_req", int'(call_req), 0);
    chk("R12 call_vec", int'(call_vec), 0);
    chk("R12 pend", int'(pend_flags), 0);
    chk("R12 in_service", int'(in_service), 0);
    rst_n = 1'b1;
    step();

    // table walk: R4 R5 R6
    for (int t = 0; t < 8; t++) begin
      clear_all();
      src_hi = TBL[t][13:4]; src_raise = TBL[t][23:14]; step();
      insn_done = 1'b1; step();
      if (TBL[t][3:0] == 4'd15) begin
        chk("R4 none", int'(call_req), 0);
      end else begin
        chk("R5 req", int'(call_req), 1);
        chk("R4_R6 vec", int'(call_vec), 3 + 8 * int'(TBL[t][3:0]));
        ack_and_return(1);
      end
    end
    clear_all();

    // R1 raise beats clear, then R2 clear
    src_raise[7] = 1'b1; sw_clear[7] = 1'b1; step();
    chk("R1 raise wins", int'(pend_flags[7]), 1);
    sw_clear[7] = 1'b1; step();
    chk("R2 sw clear", int'(pend_flags[7]), 0);

    // R3 masking
    glb_en = 1'b0; src_raise[4] = 1'b1; step();
    insn_done = 1'b1; step();
    chk("R3 global off", int'(call_req), 0);
    glb_en = 1'b1; src_en[4] = 1'b0; insn_done = 1'b1; step();
    chk("R3 source off", int'(call_req), 0);
    src_en[4] = 1'b1; insn_done = 1'b1; step();
    chk("R3 enabled vec", int'(call_vec), 16'h0023);
    ack_and_return(1);
    chk("R2 sw flag kept", int'(pend_flags[4]), 1);
    clear_all();

    // R11 stall
    src_raise[1] = 1'b1; step();
    stall = 1'b1; insn_done = 1'b1; step();
    chk("R11 stalled", int'(call_req), 0);
    stall = 1'b0; step();
    chk("R11 missed boundary", int'(call_req), 0);
    insn_done = 1'b1; step();
    chk("R11 after stall vec", int'(call_vec), 16'h000B);
    ack_and_return(1);
    clear_all();

    // R7 hold, R2 hw/sw clear on ack, R9 preemption
    src_raise[6] = 1'b1; step();
    insn_done = 1'b1; step();
    chk("R7 vec src6", int'(call_vec), 16'h0033);
    src_hi[0] = 1'b1; src_raise[0] = 1'b1; step();
    insn_done = 1'b1; step();
    chk("R7 held req", int'(call_req), 1);
    chk("R7 held vec", int'(call_vec), 16'h0033);
    call_ack = 1'b1; step();
    chk("R7 req after ack", int'(call_req), 0);
    chk("R8 lo in service", int'(in_service), 1);
    chk("R2 src6 kept", int'(pend_flags[6]), 1);
    insn_done = 1'b1; step();
    chk("R9 hi preempts", int'(call_vec), 16'h0003);
    call_ack = 1'b1; step();
    chk("R8 both in service", int'(in_service), 3);
    chk("R2 src0 hw clear", int'(pend_flags[0]), 0);
    ack_and_return(0);
    clear_all();
    reti_done = 1'b1; insn_done = 1'b1; step();
    chk("R8 hi popped", int'(in_service), 1);
    reti_done = 1'b1; insn_done = 1'b1; step();
    chk("R8 lo popped", int'(in_service), 0);

    // R9 low blocked, R10 return gap
    src_raise[0] = 1'b1; step();
    insn_done = 1'b1; step();
    call_ack = 1'b1; step();
    src_raise[3] = 1'b1; step();
    insn_done = 1'b1; step();
    chk("R9 lo blocked", int'(call_req), 0);
    reti_done = 1'b1; insn_done = 1'b1; step();
    chk("R10 no call at return", int'(call_req), 0);
    chk("R10 svc empty", int'(in_service), 0);
    insn_done = 1'b1; step();
    chk("R10 call after gap", int'(call_vec), 16'h001B);
    chk("R10 req after gap", int'(call_req), 1);
    ack_and_return(1);
    clear_all();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule